// File: doc/BRIEF.md
# Branch Condition and Target Unit

This block resolves control transfers for an 8-bit microcontroller core. The core presents a branch request with the address of the next sequential instruction, a branch kind and the operands that kind needs. One clock later the block reports three things. It says whether the branch is taken. It gives the program counter to fetch from next. It also gives any side effect the branch produces: a carry write for compare-and-jump, a decremented byte for decrement-and-jump, and a clear request for the tested bit of jump-if-bit-set-and-clear.

Four target modes are supported:
- a signed 8-bit displacement from the next instruction;
- a full 16-bit address;
- an 11-bit address inside the current 2 KB page;
- the accumulator added to the 16-bit data pointer.

Conditional kinds test the accumulator for zero, the carry, a selected bit, the inequality of two unsigned bytes, or a decremented byte. Stack handling for calls and returns, and instruction fetch, belong to other blocks.

Top module: `br_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is 0 after that edge.
- R2: A request sampled with `req_valid`=1 produces `rsp_valid`=1 on the next cycle. `next_pc` is then the target when `taken`=1 and `seq_pc` when `taken`=0.
- R3: Kind 0 (short relative) is always taken. Its target is `seq_pc` plus `rel_off` sign-extended, modulo 2^16. Every conditional kind (4 to 12) uses this same relative target when taken.
- R4: Kind 1 (long) is always taken, with target `long_addr`.
- R5: Kind 2 (page absolute) is always taken. Its target is {`seq_pc`[15:11], `page_hi`[2:0], `addr_lo`[7:0]}, so bits 15:11 are those of the next instruction's address.
- R6: Kind 3 (indexed) is always taken. Its target is `dptr` plus the zero-extended `acc`, modulo 2^16.
- R7: Kind 4 is taken when `acc`==0. Kind 5 is taken when `acc`!=0.
- R8: Kind 6 is taken when `cy_in`=1 and kind 7 when `cy_in`=0. Kind 8 is taken when `bit_in`=1 and kind 9 when `bit_in`=0.
- R9: Kind 10 is taken when `bit_in`=1. In that case it raises `bit_clr`=1. With `bit_in`=0 it is neither taken nor raises `bit_clr`.
- R10: Kind 11 is taken when `cmp_a`!=`cmp_b` (unsigned). It raises `cy_wr`=1 with `cy_out`=1 when `cmp_a`<`cmp_b` and `cy_out`=0 otherwise.
- R11: Kind 12 sets `dec_wr`=1 and `dec_out`=`dec_opnd`-1 modulo 256. It is taken when that result is non-zero.
- R12: Kinds 13 to 15 are not taken and produce no side effect. `next_pc` equals `seq_pc`.
- R13: In a cycle after `req_valid`=0, `rsp_valid`, `taken`, `cy_wr`, `dec_wr` and `bit_clr` are 0. `next_pc`, `cy_out` and `dec_out` keep their previous values. `cy_out` and `dec_out` change only together with their write flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Branch request present this cycle |
| br_kind | input | 4 | Branch kind code (0 to 15) |
| seq_pc | input | 16 | Address of the next sequential instruction |
| rel_off | input | 8 | Signed relative displacement |
| page_hi | input | 3 | Page-address bits 10:8 from the opcode byte |
| addr_lo | input | 8 | Page-address bits 7:0 |
| long_addr | input | 16 | Full 16-bit target |
| acc | input | 8 | Accumulator |
| dptr | input | 16 | Data pointer |
| cy_in | input | 1 | Current carry flag |
| bit_in | input | 1 | Value of the selected bit |
| cmp_a | input | 8 | First compare operand |
| cmp_b | input | 8 | Second compare operand |
| dec_opnd | input | 8 | Operand for decrement-and-jump |
| rsp_valid | output | 1 | Response present |
| taken | output | 1 | Branch taken |
| next_pc | output | 16 | Next program counter |
| cy_wr | output | 1 | Carry write request |
| cy_out | output | 1 | New carry value |
| dec_wr | output | 1 | Decremented value write request |
| dec_out | output | 8 | Decremented value |
| bit_clr | output | 1 | Request to clear the tested bit |

## Verification
The assertions check a set of properties on every cycle:
- idle responses are quiet, and a not-taken response returns the sequential address;
- a bit clear never occurs without a taken branch;
- the taken flag of decrement-and-jump agrees with its reported result;
- the compare carry matches the operands of the previous cycle;
- a page target stays inside the page of the next instruction.

Some behaviours only the bench's scenarios can show: the exact target arithmetic, including wrap past 0xFFFF for relative and indexed modes; the correct condition polarity for each kind; and the retention of held outputs across idle cycles.

// File: rtl/br_pkg.sv
// Package: branch kind codes and the condition/side-effect record shared by
// the branch unit's submodules. Assumes a 4-bit kind field; unlisted codes
// are treated as "no branch".
package br_pkg;

    typedef enum logic [3:0] {
        BK_SHORT    = 4'd0,
        BK_LONG     = 4'd1,
        BK_PAGE     = 4'd2,
        BK_INDEX    = 4'd3,
        BK_ZERO     = 4'd4,
        BK_NZERO    = 4'd5,
        BK_CSET     = 4'd6,
        BK_CCLR     = 4'd7,
        BK_BSET     = 4'd8,
        BK_BCLR     = 4'd9,
        BK_BTSTCLR  = 4'd10,
        BK_CMPNE    = 4'd11,
        BK_DECNZ    = 4'd12
    } br_kind_e;

    typedef struct packed {
        logic taken;
        logic cy_wr;
        logic cy_val;
        logic dec_wr;
        logic bit_clr;
    } br_cond_t;

endpackage

// File: rtl/br_target_gen.sv
// br_target_gen: combinational target address generator.
// Produces the branch target for the relative, long, page-absolute and
// indexed modes. Assumes seq_pc already points past the branch instruction;
// all additions wrap at PC_W bits.
module br_target_gen
    import br_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DW     = 8,
    parameter int PAGE_W = 11
) (
    input  logic [3:0]           kind,
    input  logic [PC_W-1:0]      seq_pc,
    input  logic [DW-1:0]        rel_off,
    input  logic [PAGE_W-DW-1:0] page_hi,
    input  logic [DW-1:0]        addr_lo,
    input  logic [PC_W-1:0]      long_addr,
    input  logic [DW-1:0]        acc,
    input  logic [PC_W-1:0]      dptr,
    output logic [PC_W-1:0]      target
);
    localparam int EXT_W = PC_W - DW;

    logic [PC_W-1:0] rel_tgt;
    logic [PC_W-1:0] idx_tgt;
    logic [PC_W-1:0] page_tgt;

    // Signed displacement and indexed sums, modulo 2^PC_W.
    always_comb begin
        rel_tgt = seq_pc + {{EXT_W{rel_off[DW-1]}}, rel_off};
        idx_tgt = dptr + {{EXT_W{1'b0}}, acc};
    end

    // Page target: keep the page bits of seq_pc when the PC is wider than a page.
    generate
        if (PC_W > PAGE_W) begin : g_page_keep
            assign page_tgt = {seq_pc[PC_W-1:PAGE_W], page_hi, addr_lo};
        end else begin : g_page_full
            assign page_tgt = {page_hi, addr_lo};
        end
    endgenerate

    // Select the target that matches the branch kind.
    always_comb begin
        case (kind)
            BK_LONG:  target = long_addr;
            BK_PAGE:  target = page_tgt;
            BK_INDEX: target = idx_tgt;
            default:  target = rel_tgt;
        endcase
    end

endmodule

// File: rtl/br_cond_eval.sv
// br_cond_eval: combinational condition and side-effect evaluator.
// Decides whether the branch is taken and which carry, decrement and
// bit-clear side effects the kind produces. Assumes unsigned compare operands.
module br_cond_eval
    import br_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [3:0]    kind,
    input  logic [DW-1:0] acc,
    input  logic          cy_in,
    input  logic          bit_in,
    input  logic [DW-1:0] cmp_a,
    input  logic [DW-1:0] cmp_b,
    input  logic [DW-1:0] dec_opnd,
    output br_cond_t      cond,
    output logic [DW-1:0] dec_val
);
    logic acc_zero;

    // Decremented operand and accumulator zero test.
    always_comb begin
        dec_val  = dec_opnd - {{(DW-1){1'b0}}, 1'b1};
        acc_zero = (acc == '0);
    end

    // Per-kind condition and side-effect selection.
    always_comb begin
        cond = '0;
        case (kind)
            BK_SHORT, BK_LONG, BK_PAGE, BK_INDEX: cond.taken = 1'b1;
            BK_ZERO:    cond.taken = acc_zero;
            BK_NZERO:   cond.taken = !acc_zero;
            BK_CSET:    cond.taken = cy_in;
            BK_CCLR:    cond.taken = !cy_in;
            BK_BSET:    cond.taken = bit_in;
            BK_BCLR:    cond.taken = !bit_in;
            BK_BTSTCLR: begin
                cond.taken   = bit_in;
                cond.bit_clr = bit_in;
            end
            BK_CMPNE: begin
                cond.taken  = (cmp_a != cmp_b);
                cond.cy_wr  = 1'b1;
                cond.cy_val = (cmp_a < cmp_b);
            end
            BK_DECNZ: begin
                cond.taken  = (dec_val != '0);
                cond.dec_wr = 1'b1;
            end
            default: cond = '0;
        endcase
    end

endmodule

// File: rtl/br_unit.sv
// br_unit: branch condition and target unit (top).
// Samples a branch request when req_valid is high and returns, one cycle
// later, the taken flag, next PC and side-effect requests. Assumes the core
// holds no other branch in flight; synchronous active-low reset.
module br_unit
    import br_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DW     = 8,
    parameter int PAGE_W = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [3:0]           br_kind,
    input  logic [PC_W-1:0]      seq_pc,
    input  logic [DW-1:0]        rel_off,
    input  logic [PAGE_W-DW-1:0] page_hi,
    input  logic [DW-1:0]        addr_lo,
    input  logic [PC_W-1:0]      long_addr,
    input  logic [DW-1:0]        acc,
    input  logic [PC_W-1:0]      dptr,
    input  logic                 cy_in,
    input  logic                 bit_in,
    input  logic [DW-1:0]        cmp_a,
    input  logic [DW-1:0]        cmp_b,
    input  logic [DW-1:0]        dec_opnd,
    output logic                 rsp_valid,
    output logic                 taken,
    output logic [PC_W-1:0]      next_pc,
    output logic                 cy_wr,
    output logic                 cy_out,
    output logic                 dec_wr,
    output logic [DW-1:0]        dec_out,
    output logic                 bit_clr
);
    logic [PC_W-1:0] target;
    br_cond_t        cond;
    logic [DW-1:0]   dec_val;

    br_target_gen #(.PC_W(PC_W), .DW(DW), .PAGE_W(PAGE_W)) u_tgt (
        .kind      (br_kind),
        .seq_pc    (seq_pc),
        .rel_off   (rel_off),
        .page_hi   (page_hi),
        .addr_lo   (addr_lo),
        .long_addr (long_addr),
        .acc       (acc),
        .dptr      (dptr),
        .target    (target)
    );

    br_cond_eval #(.DW(DW)) u_cond (
        .kind     (br_kind),
        .acc      (acc),
        .cy_in    (cy_in),
        .bit_in   (bit_in),
        .cmp_a    (cmp_a),
        .cmp_b    (cmp_b),
        .dec_opnd (dec_opnd),
        .cond     (cond),
        .dec_val  (dec_val)
    );

    // Response register: pulse flags per request, hold data between requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            taken     <= 1'b0;
            next_pc   <= '0;
            cy_wr     <= 1'b0;
            cy_out    <= 1'b0;
            dec_wr    <= 1'b0;
            dec_out   <= '0;
            bit_clr   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            taken     <= req_valid && cond.taken;
            cy_wr     <= req_valid && cond.cy_wr;
            dec_wr    <= req_valid && cond.dec_wr;
            bit_clr   <= req_valid && cond.bit_clr;
            if (req_valid) begin
                next_pc <= cond.taken ? target : seq_pc;
            end
            if (req_valid && cond.cy_wr) begin
                cy_out <= cond.cy_val;
            end
            if (req_valid && cond.dec_wr) begin
                dec_out <= dec_val;
            end
        end
    end

    // R13: an idle cycle carries no taken flag or side effect.
    a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(taken || cy_wr || dec_wr || bit_clr));

    // R2: a not-taken response returns the sequential address of the request.
    a_r2_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid) && rsp_valid && !taken |-> next_pc == $past(seq_pc));

    // R9: a bit clear request only accompanies a taken branch.
    a_r9_clear_taken: assert property (@(posedge clk) disable iff (!rst_n)
        bit_clr |-> taken);

    // R11: decrement-and-jump is taken exactly when its result is non-zero.
    a_r11_dec_taken: assert property (@(posedge clk) disable iff (!rst_n)
        dec_wr |-> (taken == (dec_out != '0)));

    // R10: the compare carry reflects unsigned less-than of the operands.
    a_r10_cmp_carry: assert property (@(posedge clk) disable iff (!rst_n)
        cy_wr |-> cy_out == ($past(cmp_a) < $past(cmp_b)));

    // R5: a page-absolute target stays in the page of the next instruction.
    a_r5_same_page: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid) && ($past(br_kind) == BK_PAGE) && rsp_valid
        |-> taken && next_pc[PC_W-1:PAGE_W] == $past(seq_pc[PC_W-1:PAGE_W]));

endmodule

// File: tb/br_unit_tb_top.sv
// Bench for br_unit: behavioural reference model compared on every clock.
module br_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [3:0]  br_kind;
    logic [15:0] seq_pc, long_addr, dptr;
    logic [7:0]  rel_off, addr_lo, acc, cmp_a, cmp_b, dec_opnd;
    logic [2:0]  page_hi;
    logic        cy_in, bit_in;
    logic        rsp_valid, taken, cy_wr, cy_out, dec_wr, bit_clr;
    logic [15:0] next_pc;
    logic [7:0]  dec_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // Model-held outputs.
    logic [15:0] m_pc  = '0;
    logic        m_cy  = 1'b0;
    logic [7:0]  m_dec = '0;
    logic [29:0] exp_v;

    always #10 clk = ~clk;

    br_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .br_kind(br_kind),
        .seq_pc(seq_pc), .rel_off(rel_off), .page_hi(page_hi),
        .addr_lo(addr_lo), .long_addr(long_addr), .acc(acc), .dptr(dptr),
        .cy_in(cy_in), .bit_in(bit_in), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .dec_opnd(dec_opnd), .rsp_valid(rsp_valid), .taken(taken),
        .next_pc(next_pc), .cy_wr(cy_wr), .cy_out(cy_out), .dec_wr(dec_wr),
        .dec_out(dec_out), .bit_clr(bit_clr)
    );

    function automatic logic [29:0] pack_out();
        return {rsp_valid, taken, next_pc, cy_wr, cy_out, dec_wr, dec_out, bit_clr};
    endfunction

    task automatic compare(string tag);
        logic [29:0] act;
        act = pack_out();
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    // Compute the expected response for the inputs currently applied.
    task automatic model_request();
        int  rel, tgt, nxt;
        bit  tk, cw, dw, bc;
        int  dv;
        rel = (int'(seq_pc) + int'($signed(rel_off))) & 32'hFFFF;
        tgt = rel; tk = 0; cw = 0; dw = 0; bc = 0;
        dv  = (int'(dec_opnd) + 255) % 256;
        case (int'(br_kind))
            0: tk = 1;
            1: begin tk = 1; tgt = int'(long_addr); end
            2: begin tk = 1; tgt = (int'(seq_pc) / 2048) * 2048 + int'(page_hi) * 256 + int'(addr_lo); end
            3: begin tk = 1; tgt = (int'(dptr) + int'(acc)) % 65536; end
            4: tk = (acc == 0);
            5: tk = (acc != 0);
            6: tk = cy_in;
            7: tk = !cy_in;
            8: tk = bit_in;
            9: tk = !bit_in;
            10: begin tk = bit_in; bc = bit_in; end
            11: begin tk = (cmp_a != cmp_b); cw = 1; m_cy = (cmp_a < cmp_b); end
            12: begin dw = 1; m_dec = dv[7:0]; tk = (dv != 0); end
            default: tk = 0;
        endcase
        nxt  = tk ? tgt : int'(seq_pc);
        m_pc = nxt[15:0];
        exp_v = {1'b1, tk, m_pc, cw, m_cy, dw, m_dec, bc};
    endtask

    // One request: inputs driven at the falling edge, checked one cycle later.
    task automatic req(input int k, input int pc, input int off, input int ph,
                       input int lo, input int la, input int a, input int dp,
                       input bit cy, input bit b, input int ca, input int cb,
                       input int dop, input string tag);
        req_valid = 1'b1; br_kind = k[3:0]; seq_pc = pc[15:0]; rel_off = off[7:0];
        page_hi = ph[2:0]; addr_lo = lo[7:0]; long_addr = la[15:0]; acc = a[7:0];
        dptr = dp[15:0]; cy_in = cy; bit_in = b; cmp_a = ca[7:0]; cmp_b = cb[7:0];
        dec_opnd = dop[7:0];
        model_request();
        @(posedge clk); @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(string tag);
        req_valid = 1'b0;
        br_kind = 4'($urandom); seq_pc = 16'($urandom); acc = 8'($urandom);
        exp_v = {1'b0, 1'b0, m_pc, 1'b0, m_cy, 1'b0, m_dec, 1'b0};
        @(posedge clk); @(negedge clk);
        compare(tag);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b1; br_kind = 4'd0; seq_pc = 16'h1234;
        rel_off = 8'h10; page_hi = '0; addr_lo = '0; long_addr = '0; acc = '0;
        dptr = '0; cy_in = 0; bit_in = 0; cmp_a = 0; cmp_b = 1; dec_opnd = 0;
        repeat (3) @(negedge clk);
        exp_v = '0;
        compare("R1 reset");
        rst_n = 1'b1;

        // R3 relative, forward and backward with wrap
        req(0, 16'h1000, 8'h05, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 fwd");
        req(0, 16'h0001, 8'hFE, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 wrap back");
        req(0, 16'hFFF0, 8'h7F, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 wrap fwd");
        // R4 long
        req(1, 16'h0100, 8'h00, 0, 0, 16'hBEEF, 0, 0, 0, 0, 0, 0, 0, "R4 long");
        // R5 page absolute
        req(2, 16'h3802, 0, 3'b111, 8'h34, 0, 0, 0, 0, 0, 0, 0, 0, "R5 page");
        req(2, 16'hF7FF, 0, 3'b000, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, "R5 page edge");
        // R6 indexed with wrap
        req(3, 16'h0000, 0, 0, 0, 0, 8'hFF, 16'hFF80, 0, 0, 0, 0, 0, "R6 idx wrap");
        req(3, 16'h0000, 0, 0, 0, 0, 8'h12, 16'h2000, 0, 0, 0, 0, 0, "R6 idx");
        // R7 accumulator zero tests
        req(4, 16'h0200, 8'h10, 0, 0, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R7 jz taken");
        req(4, 16'h0200, 8'h10, 0, 0, 0, 8'h05, 0, 0, 0, 0, 0, 0, "R7 jz not");
        req(5, 16'h0200, 8'h80, 0, 0, 0, 8'h05, 0, 0, 0, 0, 0, 0, "R7 jnz taken");
        req(5, 16'h0200, 8'h80, 0, 0, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R7 jnz not");
        // R8 carry and bit tests
        req(6, 16'h0300, 8'h20, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R8 jc set");
        req(6, 16'h0300, 8'h20, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 jc clr");
        req(7, 16'h0300, 8'h20, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 jnc");
        req(8, 16'h0300, 8'hF0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R8 jb");
        req(9, 16'h0300, 8'hF0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R8 jnb not");
        // R9 test-and-clear
        req(10, 16'h0400, 8'h08, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R9 jbc set");
        req(10, 16'h0400, 8'h08, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 jbc clr");
        // R10 compare
        req(11, 16'h0500, 8'h04, 0, 0, 0, 0, 0, 0, 0, 8'h10, 8'h20, 0, "R10 lt");
        req(11, 16'h0500, 8'h04, 0, 0, 0, 0, 0, 1, 0, 8'hF0, 8'h20, 0, "R10 gt");
        req(11, 16'h0500, 8'h04, 0, 0, 0, 0, 0, 1, 0, 8'h33, 8'h33, 0, "R10 eq");
        // R11 decrement
        req(12, 16'h0600, 8'hFC, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h01, "R11 to zero");
        req(12, 16'h0600, 8'hFC, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R11 wrap");
        req(12, 16'h0600, 8'hFC, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h05, "R11 mid");
        // R12 unused kinds
        for (int k = 13; k < 16; k++)
            req(k, 16'h0700, 8'h40, 3'b101, 8'h11, 16'h9999, 8'h01, 16'h1111, 1, 1,
                8'h01, 8'h02, 8'h03, "R12 unused");
        // R13 idle cycles hold data
        repeat (3) idle("R13 idle");

        // R2 random mix of requests and idles
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 3) == 0) idle("R13 rand idle");
            else req(int'($urandom_range(0, 15)), int'($urandom), int'($urandom),
                     int'($urandom), int'($urandom), int'($urandom), int'($urandom),
                     int'($urandom), bit'($urandom), bit'($urandom),
                     int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                     int'($urandom_range(0, 2)), "R2 random");
        end

        // R1 reset again in the middle of traffic
        rst_n = 1'b0; req_valid = 1'b1; br_kind = 4'd11;
        @(posedge clk); @(negedge clk);
        m_pc = '0; m_cy = 0; m_dec = '0; exp_v = '0;
        compare("R1 mid reset");
        rst_n = 1'b1;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule